// File: doc/BRIEF.md
# Triggered Audio Word Counter Capture

This block counts completed sample words on a serial audio link in a 10-bit counter. When a chosen event arrives, it copies the counter into a snapshot register and restarts the count from zero in the same cycle. The event can come from one of three hardware trigger lines, picked by a 2-bit select field. A software write to the snapshot register also forces a copy and clear.

Software reads the snapshot over a byte-wide register bus. The low eight bits are in a data byte. The upper two bits are in the low bits of a status byte. The intended use is measuring how many audio words pass between periodic events, such as bus frame starts or timer ticks. The serial framing logic and the trigger sources are outside this block.

Top module: `wcnt_capture_top`

## Requirements
- R1: After reset, the live counter, the snapshot and the trigger select are all zero, so every register reads 0x00.
- R2: Each cycle with `word_done_i` high advances the live counter by one.
- R3: The live counter wraps from 1023 to 0 without saturating.
- R4: A write of any data to address 1 copies the live counter into the snapshot and clears the counter. Snapshot bits 7:0 read at address 1, and snapshot bits 9:8 read at bits 1:0 of address 2. This happens whatever the trigger select holds.
- R5: With trigger select 0 (bits 1:0 of address 0), no hardware trigger input has any effect on the snapshot or the counter.
- R6: Trigger select 1, 2 and 3 pick `trig_i[0]`, `trig_i[1]` and `trig_i[2]`. A rising edge on the picked input captures and clears, and the other inputs are ignored.
- R7: A trigger input held high causes exactly one capture, on its rising edge.
- R8: When a word completes in the same cycle as a capture, the snapshot excludes that word and the counter restarts at 1.
- R9: A software write and a hardware trigger in the same cycle produce a single capture and clear.
- R10: The snapshot holds its value until the next capture.
- R11: Address 0 reads back the trigger select in bits 1:0. Writes to address 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_done_i | input | 1 | One-cycle strobe per completed audio word |
| trig_i | input | 3 | Hardware trigger lines, sampled in the block clock domain |
| addr_i | input | 2 | Register address: 0 select, 1 snapshot low, 2 status |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |

## Verification
Assertions check the following on every cycle:
- the counter holds when no word completes and no capture occurs;
- it wraps at the top of its range;
- a capture takes the pre-clear count and restarts at 0 or 1 depending on a coincident word;
- the snapshot holds between captures;
- select 0 never produces a hardware event;
- one trigger source cannot fire on two consecutive cycles.

Some behaviour can only be shown by the bench scenarios:
- that the correct line is picked for each select value and the other lines are ignored;
- that a held line captures only once;
- that a simultaneous software and hardware trigger clears only once;
- that the 10-bit snapshot is split correctly between the two bytes at 1023 and after a wrap.

// File: rtl/wcnt_pkg.sv
package wcnt_pkg;
  localparam int unsigned N_SRC  = 3;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [SEL_W-1:0] {
    TSEL_NONE = 2'd0,
    TSEL_SRC0 = 2'd1,
    TSEL_SRC1 = 2'd2,
    TSEL_SRC2 = 2'd3
  } tsel_e;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_SNAP = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/wcnt_edge_sel.sv
module wcnt_edge_sel
  import wcnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  tsel_e            sel_i,
  output logic             evt_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;

  for (genvar k = 0; k < N_SRC; k++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[k] <= 1'b0;
      else         src_q[k] <= src_i[k];
    end
    assign rise[k] = src_i[k] & ~src_q[k];
  end

  always_comb begin
    unique case (sel_i)
      TSEL_SRC0: evt_o = rise[0];
      TSEL_SRC1: evt_o = rise[1];
      TSEL_SRC2: evt_o = rise[2];
      default:   evt_o = 1'b0;
    endcase
  end

  p_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == TSEL_NONE) |-> !evt_o);

  // same source cannot fire two cycles running
  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> (!evt_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/wcnt_core.sv
module wcnt_core #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_done_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] inc;

  assign inc = {{(CNT_W-1){1'b0}}, word_done_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (clr_i) begin
      snap_q <= cnt_q;
      cnt_q  <= inc;  // coincident word counts toward next interval
    end else begin
      cnt_q  <= cnt_q + inc;
    end
  end

  assign snap_o = snap_q;

  p_hold_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !word_done_i) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && word_done_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && word_done_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> snap_q == $past(cnt_q));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && word_done_i) |=> cnt_q == CNT_W'(1));
  p_restart0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !word_done_i) |=> cnt_q == '0);
  p_hold_snap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(snap_q));
endmodule

// File: rtl/wcnt_regs.sv
module wcnt_regs
  import wcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic [BYTE_W-1:0] rdata_o,
  output tsel_e             sel_o,
  output logic              sw_trig_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  tsel_e sel_q;
  logic  unused_wdata;

  assign unused_wdata = ^wdata_i[BYTE_W-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       sel_q <= TSEL_NONE;
    else if (wr_i && addr_i == ADDR_CFG) sel_q <= tsel_e'(wdata_i[SEL_W-1:0]);
  end

  assign sw_trig_o = wr_i && (addr_i == ADDR_SNAP);
  assign sel_o     = sel_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG:  rdata_o[SEL_W-1:0] = sel_q;
      ADDR_SNAP: rdata_o = snap_i[BYTE_W-1:0];
      ADDR_STAT: rdata_o[HI_W-1:0] = snap_i[CNT_W-1:BYTE_W];
      default:   rdata_o = '0;
    endcase
  end

  p_stat_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != ADDR_CFG) |=> $stable(sel_q));
endmodule

// File: rtl/wcnt_capture_top.sv
module wcnt_capture_top
  import wcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_done_i,
  input  logic [N_SRC-1:0]  trig_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  tsel_e            sel;
  logic             hw_evt;
  logic             sw_trig;
  logic             clr;
  logic [CNT_W-1:0] snap;

  wcnt_edge_sel u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (trig_i),
    .sel_i (sel),
    .evt_o (hw_evt)
  );

  // software and hardware merge into one clear
  assign clr = sw_trig | hw_evt;

  wcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_done_i(word_done_i),
    .clr_i      (clr),
    .snap_o     (snap)
  );

  wcnt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .snap_i   (snap),
    .rdata_o  (rdata_o),
    .sel_o    (sel),
    .sw_trig_o(sw_trig)
  );

  p_sw_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_SNAP) |-> clr);
endmodule

// File: tb/sim_wcnt_capture_top.sv
module sim_wcnt_capture_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       word_done_i = 1'b0;
  logic [2:0] trig_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference
  int m_cnt, m_snap, m_sel;
  logic [2:0] m_tq;

  wcnt_capture_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_done_i(word_done_i), .trig_i(trig_i),
    .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_snap = 0; m_sel = 0; m_tq = '0;
    end else begin
      logic [2:0] rise;
      bit hw, sw;
      rise = trig_i & ~m_tq;
      hw = (m_sel != 0) && rise[m_sel-1];
      sw = wr_i && addr_i == 2'd1;
      if (hw || sw) begin
        m_snap = m_cnt;
        m_cnt = word_done_i ? 1 : 0;
      end else begin
        m_cnt = (m_cnt + (word_done_i ? 1 : 0)) % 1024;
      end
      if (wr_i && addr_i == 2'd0) m_sel = wdata_i[1:0];
      m_tq = trig_i;
    end
  end

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return m_sel;
      2'd1: return m_snap % 256;
      2'd2: return m_snap / 256;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (int'(rdata_o) != model_read(addr_i)) begin
        errors++;
        $display("FAIL %s addr %0d actual %0d expected %0d",
                 addr_i == 2'd0 ? "R11" : "R4", addr_i, rdata_o, model_read(addr_i));
      end
    end
  end

  task automatic step(bit wd, logic [2:0] trg, bit wr, logic [1:0] a, logic [7:0] d);
    @(posedge clk_i); #1;
    word_done_i = wd; trig_i = trg; wr_i = wr; addr_i = a; wdata_i = d;
  endtask

  task automatic words(int n, logic [2:0] trg);
    for (int i = 0; i < n; i++) step(1'b1, trg, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    @(posedge clk_i); #1;
    word_done_i = 1'b0; wr_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    checks++;
    if (int'(rdata_o) != exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %0d expected %0d", tag, a, rdata_o, exp);
    end
  endtask

  task automatic snap_is(int exp, string tag);
    rd(2'd1, exp % 256, tag);
    rd(2'd2, exp / 256, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, 0, "R1"); snap_is(0, "R1");
    // R2 + R4: count then software capture, any data
    words(5, 3'b000);
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'hA5);
    snap_is(5, "R4");
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(0, "R2");
    // R5: select none ignores hardware lines
    step(1'b1, 3'b111, 1'b0, 2'd0, 8'h00);
    step(1'b1, 3'b000, 1'b0, 2'd0, 8'h00);
    step(1'b1, 3'b111, 1'b0, 2'd0, 8'h00);
    step(1'b0, 3'b000, 1'b0, 2'd0, 8'h00);
    snap_is(0, "R5");
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(3, "R5");
    // R6: select 1 picks line 0 only
    step(1'b0, 3'b000, 1'b1, 2'd0, 8'h01);
    rd(2'd0, 1, "R11");
    words(7, 3'b000);
    step(1'b0, 3'b110, 1'b0, 2'd0, 8'h00);
    step(1'b0, 3'b000, 1'b0, 2'd0, 8'h00);
    snap_is(3, "R6");
    step(1'b0, 3'b001, 1'b0, 2'd0, 8'h00);
    snap_is(7, "R6");
    // R7 + R10: held line captures once, snapshot holds
    step(1'b0, 3'b000, 1'b0, 2'd0, 8'h00);
    words(4, 3'b000);
    step(1'b0, 3'b001, 1'b0, 2'd0, 8'h00);
    words(2, 3'b001);
    snap_is(4, "R7");
    snap_is(4, "R10");
    step(1'b0, 3'b001, 1'b1, 2'd1, 8'h00);
    snap_is(2, "R7");
    // R8: coincident word excluded, counter restarts at 1
    step(1'b0, 3'b000, 1'b1, 2'd0, 8'h02);
    words(6, 3'b000);
    step(1'b1, 3'b010, 1'b0, 2'd0, 8'h00);
    step(1'b0, 3'b000, 1'b0, 2'd0, 8'h00);
    snap_is(6, "R8");
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(1, "R8");
    // R9: simultaneous software and hardware capture
    step(1'b0, 3'b000, 1'b1, 2'd0, 8'h03);
    words(3, 3'b000);
    step(1'b0, 3'b100, 1'b1, 2'd1, 8'h00);
    snap_is(3, "R9");
    words(2, 3'b000);
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(2, "R9");
    // R11: status writes ignored, select reads back
    step(1'b0, 3'b000, 1'b1, 2'd2, 8'hFF);
    rd(2'd0, 3, "R11");
    snap_is(2, "R11");
    // R3: full range and wrap
    step(1'b0, 3'b000, 1'b1, 2'd0, 8'h00);
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    words(1023, 3'b000);
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(1023, "R3");
    words(1025, 3'b000);
    step(1'b0, 3'b000, 1'b1, 2'd1, 8'h00);
    snap_is(1, "R3");
    rd(2'd0, 0, "R11");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule